// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between the host bus of a NOR-style flash device and its erase/program engine. It watches write cycles on the bus, each marked by a write strobe and a chip-enable strobe. It captures the address and data of each write and interprets the low byte of the data as a command. From those commands it decides what a read of the device returns: array contents, an identifier code chosen by the low read-address bit, or a status byte.

Block erase and word program are two-write sequences. The block checks the second write and then either fires a one-cycle start pulse, with the latched address and data, toward the engine, or rejects the attempt and records an error. The topmost address region is treated as boot blocks. A write aimed there is refused unless the write-protect input is high or the reset pin sits at its high-voltage level. Single-write commands return the device to array reads, clear error flags, and ask the engine to suspend or resume.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write of command byte FFh, from any read mode, selects array reads (readSel = 0), and rdData then equals arrayData.
- R2: Command 90h selects identifier reads (readSel = 1). rdData returns MFR_CODE when rdIdAddr is 0 and DEV_CODE when rdIdAddr is 1.
- R3: Command 70h selects status reads (readSel = 2). rdData is the zero-extended status byte whatever rdIdAddr is. The status bits are: bit 7 ready (= not engBusy), bit 6 suspended, bit 5 erase error, bit 4 program error, bit 1 protect error, and all others 0.
- R4: Command 50h clears status bits 5, 4 and 1 and leaves the read mode unchanged.
- R5: 20h followed by D0h gives one eraseStart pulse, with opAddr equal to the second write's address. Reads then return status.
- R6: Either 40h or 10h followed by any write gives one progStart pulse, with opAddr and opData taken from the second write. Reads then return status.
- R7: If the write after 20h is not D0h, no operation starts, status bits 5 and 4 are both set, and reads return status.
- R8: An erase or program whose second-write address has all bits from BOOT_SHIFT upward set is refused when wpHigh and rpHv are both low. A refusal sets bit 1 together with bit 5 (for an erase) or bit 4 (for a program). With either input high, the operation starts.
- R9: B0h gives one suspendReq pulse and sets bit 6. D0h given outside an erase sequence gives one resumeReq pulse and clears bit 6. Both select status reads.
- R10: A write is captured when the first of weN and ceN rises after both were low. The later rise of the other strobe, and bus changes in between, cause no second capture.
- R11: Any other command byte in a read mode starts nothing and leaves the read mode unchanged.
- R12: A command's effect appears at the ports after the second rising clock edge that samples the strobe release, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| weN | input | 1 | Write strobe, active low |
| ceN | input | 1 | Chip enable, active low |
| busAddr | input | ADDR_W | Write-cycle address |
| busData | input | DATA_W | Write-cycle data; low byte is the command |
| wpHigh | input | 1 | Write-protect pin high: boot blocks unlocked |
| rpHv | input | 1 | Reset pin at high voltage: boot blocks unlocked |
| engBusy | input | 1 | Erase/program engine busy |
| rdIdAddr | input | 1 | Low read-address bit selecting the identifier code |
| arrayData | input | DATA_W | Data from the memory array |
| rdData | output | DATA_W | Read data returned to the bus |
| readSel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| eraseStart | output | 1 | One-cycle erase start pulse |
| progStart | output | 1 | One-cycle program start pulse |
| opAddr | output | ADDR_W | Latched target address |
| opData | output | DATA_W | Latched program data |
| suspendReq | output | 1 | One-cycle suspend request |
| resumeReq | output | 1 | One-cycle resume request |

## Verification
The assertions assume that busAddr and busData hold steady on the clock edge where a strobe release is sampled. They also assume that every bus write holds both strobes low for at least one sampled edge, and that wpHigh and rpHv do not change in the cycle a captured write is decoded. The bench drives every input one time unit after a rising edge and holds each write low for a full cycle, so it keeps within these assumptions. It also varies which strobe rises first, and it changes the bus while one strobe is still low, to exercise the capture rule.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_ID     = 2'd1,
    SRC_STATUS = 2'd2
  } readSrc_t;

  typedef enum logic [2:0] {
    ST_ARRAY  = 3'd0,
    ST_IDENT  = 3'd1,
    ST_STATUS = 3'd2,
    ST_ESETUP = 3'd3,
    ST_PSETUP = 3'd4
  } cmdState_t;

  typedef struct packed {
    logic loadOp;
    logic setEraseErr;
    logic setProgErr;
    logic setProtErr;
    logic clrErr;
    logic setSusp;
    logic clrSusp;
  } ctrlStrb_t;

  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROG_A  = 8'h40;
  localparam logic [7:0] OP_PROG_B  = 8'h10;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;

endpackage

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BOOT_SHIFT = 17,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h005A,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h00C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              weN,
  input  logic              ceN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  ctrlStrb_t         strb,
  input  readSrc_t          readSrc,
  input  logic              engBusy,
  input  logic              rdIdAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic              busWr,
  output logic [7:0]        cmdByte,
  output logic              bootHit,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [DATA_W-1:0] rdData
);

  localparam int BOOT_W = ADDR_W - BOOT_SHIFT;
  localparam int PAD_W  = DATA_W - 8;

  logic              bothLowQ;
  logic              strobeDone;
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;
  logic              suspF, eraseErrF, progErrF, protErrF;
  logic [7:0]        statusByte;

  // A write ends when the first strobe releases after both were low.
  assign strobeDone = bothLowQ && (weN || ceN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bothLowQ <= 1'b0;
      busWr    <= 1'b0;
      capAddr  <= '0;
      capData  <= '0;
    end else begin
      bothLowQ <= !weN && !ceN;
      busWr    <= strobeDone;
      if (strobeDone) begin
        capAddr <= busAddr;
        capData <= busData;
      end
    end
  end

  assign cmdByte = capData[7:0];
  assign bootHit = &capAddr[ADDR_W-1 -: BOOT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr <= '0;
      opData <= '0;
    end else if (strb.loadOp) begin
      opAddr <= capAddr;
      opData <= capData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      suspF     <= 1'b0;
      eraseErrF <= 1'b0;
      progErrF  <= 1'b0;
      protErrF  <= 1'b0;
    end else begin
      if (strb.setSusp)      suspF <= 1'b1;
      else if (strb.clrSusp) suspF <= 1'b0;
      if (strb.clrErr) begin
        eraseErrF <= 1'b0;
        progErrF  <= 1'b0;
        protErrF  <= 1'b0;
      end else begin
        if (strb.setEraseErr) eraseErrF <= 1'b1;
        if (strb.setProgErr)  progErrF  <= 1'b1;
        if (strb.setProtErr)  protErrF  <= 1'b1;
      end
    end
  end

  assign statusByte = {!engBusy, suspF, eraseErrF, progErrF, 2'b00, protErrF, 1'b0};

  always_comb begin
    unique case (readSrc)
      SRC_ARRAY: rdData = arrayData;
      SRC_ID:    rdData = rdIdAddr ? DEV_CODE : MFR_CODE;
      default:   rdData = {{PAD_W{1'b0}}, statusByte};
    endcase
  end

  // Capture is a single-cycle event per bus write.
  p_single_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> !busWr);

  // The captured write only changes together with a capture event.
  p_capture_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capAddr) |-> busWr);

  // Operation registers follow the write that was accepted.
  p_op_latch_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOp |=> (opAddr == $past(capAddr)) && (opData == $past(capData)));

  // Clearing leaves every error flag low on the next cycle.
  p_clear_errors_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrErr |=> !(eraseErrF || progErrF || protErrF));

endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [7:0] cmdByte,
  input  logic       bootHit,
  input  logic       wpHigh,
  input  logic       rpHv,
  output ctrlStrb_t  strb,
  output readSrc_t   readSrc,
  output logic       eraseStart,
  output logic       progStart,
  output logic       suspendReq,
  output logic       resumeReq
);

  cmdState_t state, stateNext;
  logic      doErase, doProg, doSusp, doResume;
  logic      bootOk;

  assign bootOk = !bootHit || wpHigh || rpHv;

  always_comb begin
    stateNext = state;
    strb      = '0;
    doErase   = 1'b0;
    doProg    = 1'b0;
    doSusp    = 1'b0;
    doResume  = 1'b0;
    if (busWr) begin
      unique case (state)
        ST_ESETUP: begin
          stateNext = ST_STATUS;
          if (cmdByte != OP_CONFIRM) begin
            strb.setEraseErr = 1'b1;
            strb.setProgErr  = 1'b1;
          end else if (bootOk) begin
            doErase     = 1'b1;
            strb.loadOp = 1'b1;
          end else begin
            strb.setEraseErr = 1'b1;
            strb.setProtErr  = 1'b1;
          end
        end
        ST_PSETUP: begin
          stateNext = ST_STATUS;
          if (bootOk) begin
            doProg      = 1'b1;
            strb.loadOp = 1'b1;
          end else begin
            strb.setProgErr = 1'b1;
            strb.setProtErr = 1'b1;
          end
        end
        default: begin
          unique case (cmdByte)
            OP_ARRAY:  stateNext = ST_ARRAY;
            OP_IDENT:  stateNext = ST_IDENT;
            OP_STATUS: stateNext = ST_STATUS;
            OP_CLEAR:  strb.clrErr = 1'b1;
            OP_ERASE:  stateNext = ST_ESETUP;
            OP_PROG_A,
            OP_PROG_B: stateNext = ST_PSETUP;
            OP_SUSPEND: begin
              doSusp       = 1'b1;
              strb.setSusp = 1'b1;
              stateNext    = ST_STATUS;
            end
            OP_CONFIRM: begin
              doResume     = 1'b1;
              strb.clrSusp = 1'b1;
              stateNext    = ST_STATUS;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_ARRAY;
      eraseStart <= 1'b0;
      progStart  <= 1'b0;
      suspendReq <= 1'b0;
      resumeReq  <= 1'b0;
    end else begin
      state      <= stateNext;
      eraseStart <= doErase;
      progStart  <= doProg;
      suspendReq <= doSusp;
      resumeReq  <= doResume;
    end
  end

  always_comb begin
    unique case (state)
      ST_ARRAY: readSrc = SRC_ARRAY;
      ST_IDENT: readSrc = SRC_ID;
      default:  readSrc = SRC_STATUS;
    endcase
  end

  // Erase only follows a completed setup write.
  p_erase_after_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> $past(state == ST_ESETUP));

  // Program only follows a program setup write.
  p_prog_after_setup_r6: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> $past(state == ST_PSETUP));

  // No start reaches a locked boot block.
  p_boot_guard_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eraseStart || progStart) |-> $past(!bootHit || wpHigh || rpHv));

  // At most one engine request per cycle.
  p_one_request_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eraseStart, progStart, suspendReq, resumeReq}));

  // Suspend and resume are single-cycle pulses.
  p_pulse_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    (suspendReq || resumeReq) |=> !(suspendReq || resumeReq));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BOOT_SHIFT = 17,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h005A,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h00C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              weN,
  input  logic              ceN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              wpHigh,
  input  logic              rpHv,
  input  logic              engBusy,
  input  logic              rdIdAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        readSel,
  output logic              eraseStart,
  output logic              progStart,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic              suspendReq,
  output logic              resumeReq
);

  ctrlStrb_t  strb;
  readSrc_t   readSrc;
  logic       busWr;
  logic [7:0] cmdByte;
  logic       bootHit;

  fcd_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_SHIFT(BOOT_SHIFT),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .weN(weN), .ceN(ceN),
    .busAddr(busAddr), .busData(busData), .strb(strb), .readSrc(readSrc),
    .engBusy(engBusy), .rdIdAddr(rdIdAddr), .arrayData(arrayData),
    .busWr(busWr), .cmdByte(cmdByte), .bootHit(bootHit),
    .opAddr(opAddr), .opData(opData), .rdData(rdData)
  );

  fcd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .cmdByte(cmdByte),
    .bootHit(bootHit), .wpHigh(wpHigh), .rpHv(rpHv),
    .strb(strb), .readSrc(readSrc),
    .eraseStart(eraseStart), .progStart(progStart),
    .suspendReq(suspendReq), .resumeReq(resumeReq)
  );

  assign readSel = readSrc;

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int BS = 17;
  localparam logic [DW-1:0] MFR = 16'h005A;
  localparam logic [DW-1:0] DEV = 16'h00C3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic weN = 1'b1, ceN = 1'b1;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busData = '0;
  logic wpHigh = 1'b0, rpHv = 1'b0, engBusy = 1'b0, rdIdAddr = 1'b0;
  logic [DW-1:0] arrayData = 16'h1357;
  logic [DW-1:0] rdData;
  logic [1:0] readSel;
  logic eraseStart, progStart, suspendReq, resumeReq;
  logic [AW-1:0] opAddr;
  logic [DW-1:0] opData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int nErase = 0, nProg = 0, nSusp = 0, nRes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .BOOT_SHIFT(BS),
                      .MFR_CODE(MFR), .DEV_CODE(DEV)) u_dut (
    .clk(clk), .rstN(rstN), .weN(weN), .ceN(ceN), .busAddr(busAddr),
    .busData(busData), .wpHigh(wpHigh), .rpHv(rpHv), .engBusy(engBusy),
    .rdIdAddr(rdIdAddr), .arrayData(arrayData), .rdData(rdData),
    .readSel(readSel), .eraseStart(eraseStart), .progStart(progStart),
    .opAddr(opAddr), .opData(opData), .suspendReq(suspendReq),
    .resumeReq(resumeReq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // mode: 0 array, 1 identifier, 2 status, 3 erase pending, 4 program pending
  int mMode = 0;
  bit mSusp = 0, mEE = 0, mPE = 0, mProt = 0;
  bit eE = 0, eP = 0, eS = 0, eR = 0;
  logic [AW-1:0] eAddr = '0;
  logic [DW-1:0] eData = '0;
  bit pend = 0, prevLow = 0;
  logic [AW-1:0] pA = '0;
  logic [DW-1:0] pD = '0;

  task automatic modelCmd(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [7:0] c = d[7:0];
    bit allowed = (a[AW-1:BS] != '1) || wpHigh || rpHv;
    if (mMode == 3) begin
      if (c != 8'hD0) begin mEE = 1; mPE = 1; end
      else if (allowed) begin eE = 1; eAddr = a; eData = d; end
      else begin mEE = 1; mProt = 1; end
      mMode = 2;
    end else if (mMode == 4) begin
      if (allowed) begin eP = 1; eAddr = a; eData = d; end
      else begin mPE = 1; mProt = 1; end
      mMode = 2;
    end else begin
      if (c == 8'hFF) mMode = 0;
      else if (c == 8'h90) mMode = 1;
      else if (c == 8'h70) mMode = 2;
      else if (c == 8'h50) begin mEE = 0; mPE = 0; mProt = 0; end
      else if (c == 8'h20) mMode = 3;
      else if (c == 8'h40 || c == 8'h10) mMode = 4;
      else if (c == 8'hB0) begin eS = 1; mSusp = 1; mMode = 2; end
      else if (c == 8'hD0) begin eR = 1; mSusp = 0; mMode = 2; end
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mSusp = 0; mEE = 0; mPE = 0; mProt = 0;
      eE = 0; eP = 0; eS = 0; eR = 0; pend = 0; prevLow = 0;
    end else begin
      eE = 0; eP = 0; eS = 0; eR = 0;
      if (pend) modelCmd(pA, pD);
      pend = prevLow && (weN || ceN);
      if (pend) begin pA = busAddr; pD = busData; end
      prevLow = !weN && !ceN;
    end
  end

  function automatic logic [DW-1:0] expRead();
    if (mMode == 0) return arrayData;
    if (mMode == 1) return rdIdAddr ? DEV : MFR;
    return {8'h00, !engBusy, mSusp, mEE, mPE, 2'b00, mProt, 1'b0};
  endfunction

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(rdData == expRead(), "R3 model rdData", rdData, expRead());
      chk(readSel == ((mMode >= 2) ? 2'd2 : 2'(mMode)), "R12 model readSel",
          readSel, mMode);
      chk(eraseStart == eE, "R5 model eraseStart", eraseStart, eE);
      chk(progStart == eP, "R6 model progStart", progStart, eP);
      chk(suspendReq == eS && resumeReq == eR, "R9 model requests",
          {suspendReq, resumeReq}, {eS, eR});
      if (eE || eP)
        chk(opAddr == eAddr && opData == eData, "R6 model operand",
            {opAddr, opData}, {eAddr, eData});
      if (eraseStart) nErase++;
      if (progStart)  nProg++;
      if (suspendReq) nSusp++;
      if (resumeReq)  nRes++;
    end
  end

  // order: 0 weN rises first, 1 ceN rises first, 2 both together
  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int order);
    @(posedge clk); #1;
    busAddr = a; busData = d; weN = 0; ceN = 0;
    @(posedge clk); #1;
    if (order == 1) ceN = 1;
    else if (order == 0) weN = 1;
    else begin weN = 1; ceN = 1; end
    @(posedge clk); #1;
    weN = 1; ceN = 1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int e0, p0;
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;
    chk(readSel == 2'd0, "R1 reset readSel", readSel, 0);
    chk(rdData == arrayData, "R1 reset rdData", rdData, arrayData);

    // R2 identifier codes
    busWrite(20'h00004, 16'h0090, 0);
    rdIdAddr = 0; #1;
    chk(readSel == 2'd1 && rdData == MFR, "R2 manufacturer code", rdData, MFR);
    rdIdAddr = 1; #1;
    chk(rdData == DEV, "R2 device code", rdData, DEV);

    // R3 status from any address, ready tracks busy
    busWrite(20'h12345, 16'h0070, 1);
    chk(rdData == 16'h0080, "R3 status idle", rdData, 16'h0080);
    engBusy = 1; #1;
    chk(rdData == 16'h0000, "R3 status busy", rdData, 16'h0000);
    engBusy = 0;

    // R5 erase
    e0 = nErase;
    busWrite(20'h00000, 16'h0020, 2);
    busWrite(20'h01234, 16'h00D0, 0);
    chk(nErase == e0 + 1 && opAddr == 20'h01234, "R5 erase start", opAddr, 20'h01234);
    chk(readSel == 2'd2, "R5 status after erase", readSel, 2);

    // R6 program with both setup bytes
    p0 = nProg;
    busWrite(20'h00000, 16'h0040, 0);
    busWrite(20'h00567, 16'hBEEF, 1);
    chk(nProg == p0 + 1 && opData == 16'hBEEF && opAddr == 20'h00567,
        "R6 program 40h", opData, 16'hBEEF);
    busWrite(20'h00000, 16'h0010, 0);
    busWrite(20'h00999, 16'h1234, 0);
    chk(nProg == p0 + 2 && opData == 16'h1234, "R6 program 10h", opData, 16'h1234);

    // R7 erase aborted
    e0 = nErase;
    busWrite(20'h00000, 16'h0020, 0);
    busWrite(20'h00100, 16'h0055, 0);
    chk(nErase == e0 && rdData == 16'h00B0, "R7 abort status", rdData, 16'h00B0);

    // R4 clear keeps status mode
    busWrite(20'h00000, 16'h0050, 0);
    chk(rdData == 16'h0080 && readSel == 2'd2, "R4 clear", rdData, 16'h0080);

    // R8 boot protection
    e0 = nErase; p0 = nProg;
    busWrite(20'h00000, 16'h0020, 0);
    busWrite(20'hE0010, 16'h00D0, 0);
    chk(nErase == e0 && rdData == 16'h00A2, "R8 boot erase refused", rdData, 16'h00A2);
    busWrite(20'h00000, 16'h0050, 0);
    busWrite(20'h00000, 16'h0040, 0);
    busWrite(20'hFFFFF, 16'h0042, 0);
    chk(nProg == p0 && rdData == 16'h0092, "R8 boot program refused", rdData, 16'h0092);
    busWrite(20'h00000, 16'h0050, 0);
    wpHigh = 1;
    busWrite(20'h00000, 16'h0020, 0);
    busWrite(20'hE0010, 16'h00D0, 0);
    chk(nErase == e0 + 1 && opAddr == 20'hE0010, "R8 boot erase with wpHigh",
        opAddr, 20'hE0010);
    wpHigh = 0; rpHv = 1;
    busWrite(20'h00000, 16'h0010, 0);
    busWrite(20'hFFFFE, 16'h0077, 0);
    chk(nProg == p0 + 1 && opAddr == 20'hFFFFE, "R8 boot program with rpHv",
        opAddr, 20'hFFFFE);
    rpHv = 0;
    // R4 clear from identifier mode leaves mode alone
    busWrite(20'h00000, 16'h0090, 0);
    busWrite(20'h00000, 16'h0050, 0);
    chk(readSel == 2'd1, "R4 mode kept", readSel, 1);

    // R9 suspend / resume
    busWrite(20'h00000, 16'h00B0, 0);
    chk(nSusp == 1 && rdData == 16'h00C0, "R9 suspend", rdData, 16'h00C0);
    busWrite(20'h00000, 16'h00D0, 0);
    chk(nRes == 1 && rdData == 16'h0080, "R9 resume", rdData, 16'h0080);

    // R1 return to array
    busWrite(20'h00000, 16'h00FF, 1);
    arrayData = 16'hA5C3; #1;
    chk(readSel == 2'd0 && rdData == 16'hA5C3, "R1 array read", rdData, 16'hA5C3);

    // R11 reserved byte, array and status modes
    e0 = nErase; p0 = nProg;
    busWrite(20'h00000, 16'h0033, 0);
    chk(readSel == 2'd0, "R11 reserved in array", readSel, 0);
    busWrite(20'h00000, 16'h0070, 0);
    busWrite(20'h00000, 16'h00E8, 0);
    chk(readSel == 2'd2 && nErase == e0 && nProg == p0 && nSusp == 1 && nRes == 1,
        "R11 reserved in status", readSel, 2);
    busWrite(20'h00000, 16'h00FF, 0);

    // R12 latency of the command effect
    @(posedge clk); #1;
    busData = 16'h0090; weN = 0; ceN = 0;
    @(posedge clk); #1 weN = 1;
    @(posedge clk); #1;
    chk(readSel == 2'd0, "R12 not after first edge", readSel, 0);
    @(posedge clk); #1;
    chk(readSel == 2'd1, "R12 after second edge", readSel, 1);
    ceN = 1;
    busWrite(20'h00000, 16'h00FF, 0);

    // R10 first release captures; later changes ignored
    @(posedge clk); #1;
    busData = 16'h0090; weN = 0; ceN = 0;
    @(posedge clk); #1 ceN = 1;
    @(posedge clk); #1 busData = 16'h0070; busAddr = 20'h00777;
    @(posedge clk); #1 weN = 1;
    repeat (4) @(posedge clk);
    #1;
    chk(readSel == 2'd1, "R10 single capture", readSel, 1);

    repeat (3) @(posedge clk);
    finish();
  end

endmodule